// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block is the front end of a short register-to-register pipeline. It holds the program counter and addresses an instruction port with it. The word the port returns is treated as the fetch-stage instruction in the same cycle. On the next clock edge that word moves into the execute stage, together with its address. Loads and stores then continue into a memory stage. Every other instruction leaves the memory stage empty, because it finishes in execute.

Branches resolve in execute and are delayed. When a branch reaches execute, the instruction after it is already being fetched. That instruction, the delay slot, always moves on to execute. Only after it does the program counter take the branch target, so the block never discards a fetched instruction. The execute unit (outside this block) returns a taken strobe and a target address. The sequencer marks each delay-slot instruction. It also raises a flag when a branch appears in a delay slot, and refuses to redirect on such a branch.

Top module: `delay_fetch`

## Requirements
- R1: While reset is held and after its release, the program counter reads 0, the execute and memory stage instructions read the all-zero no-operation word, the execute address reads 0, and both flags are low.
- R2: With no redirect, the program counter rises by 4 at every clock edge. The word presented on the instruction port during a cycle is the execute instruction after the next edge, with the execute address equal to that cycle's program counter.
- R3: A branch (bits 31:28 equal to 4'hC) in execute with the taken strobe high, and not itself in a delay slot, still lets the following instruction enter execute. The program counter then takes the target at that same edge, so the target instruction enters execute one cycle after the delay slot.
- R4: A branch in execute with the taken strobe low leaves sequential fetch unchanged: the delay slot and the instruction after it execute in address order.
- R5: The delay-slot flag is high for exactly the execute instruction that immediately follows a branch in execute, whether or not that branch was taken, and low otherwise.
- R6: A load (bits 31:28 equal to 4'h8) or a store (4'h9) in execute appears unchanged in the memory stage one cycle later. Any other instruction leaves the all-zero word in the memory stage.
- R7: A branch in execute that is itself in a delay slot raises the illegal-sequence flag, and its taken strobe is ignored: the program counter steps by 4.
- R8: The taken strobe is ignored whenever the execute instruction is not a branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instrIn | input | 32 | Instruction word read at the current program counter |
| brTaken | input | 1 | Taken strobe from execute for the branch now in execute |
| brTarget | input | 32 | Target address from execute |
| pcOut | output | 32 | Program counter, the fetch address |
| exInstr | output | 32 | Instruction in the execute stage |
| exPc | output | 32 | Address of the execute-stage instruction |
| exDelaySlot | output | 1 | High when the execute instruction sits in a delay slot |
| memInstr | output | 32 | Instruction in the memory stage, zero if none |
| illegalSeq | output | 1 | High when a branch sits in a delay slot |

## Verification
On every cycle, the assertions check the following:
- how the program counter responds to the execute-stage opcode and the taken strobe, whether redirecting, stepping, or ignoring a stray strobe;
- that the execute stage takes the fetched word and its address;
- that the delay-slot flag follows each branch by one cycle;
- that only loads and stores move into the memory stage.

Only the directed scenarios show the order of execution across a whole branch sequence. This covers the delay slot running before the target, the instruction past the slot never executing after a taken branch, and a nested branch in a slot leaving the outer redirect in force.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int OPW = 4;
  localparam logic [OPW-1:0] OP_LOAD   = 4'h8;
  localparam logic [OPW-1:0] OP_STORE  = 4'h9;
  localparam logic [OPW-1:0] OP_BRANCH = 4'hC;

  typedef struct packed {
    logic redirect;
    logic toMem;
    logic markSlot;
  } fetchStrb_t;

  function automatic logic isBranchOp(input logic [OPW-1:0] op);
    return op == OP_BRANCH;
  endfunction

  function automatic logic isMemOp(input logic [OPW-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic [OPW-1:0] exOp,
  input  logic           exSlot,
  input  logic           brTaken,
  output fetchStrb_t     strb,
  output logic           illegal
);
  logic isBr;

  always_comb begin
    isBr          = isBranchOp(exOp);
    strb.redirect = isBr && brTaken && !exSlot;
    strb.toMem    = isMemOp(exOp);
    strb.markSlot = isBr;
    illegal       = isBr && exSlot;
  end
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] instrIn,
  input  logic [XLEN-1:0] brTarget,
  input  fetchStrb_t      strb,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] exInstr,
  output logic [XLEN-1:0] exPc,
  output logic            exSlot,
  output logic [XLEN-1:0] memInstr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= '0;
      exInstr  <= '0;
      exPc     <= '0;
      exSlot   <= 1'b0;
      memInstr <= '0;
    end else begin
      pc       <= strb.redirect ? brTarget : pc + STEP;
      exInstr  <= instrIn;
      exPc     <= pc;
      exSlot   <= strb.markSlot;
      memInstr <= strb.toMem ? exInstr : '0;
    end
  end

  // R2
  ex_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (exPc == $past(pc)) && (exInstr == $past(instrIn)));

  // R6
  mem_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    isMemOp(exInstr[XLEN-1 -: OPW]) |=> memInstr == $past(exInstr));

  // R6
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMemOp(exInstr[XLEN-1 -: OPW]) |=> memInstr == '0);
endmodule

// File: rtl/delay_fetch.sv
module delay_fetch
  import fetch_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] instrIn,
  input  logic            brTaken,
  input  logic [XLEN-1:0] brTarget,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] exInstr,
  output logic [XLEN-1:0] exPc,
  output logic            exDelaySlot,
  output logic [XLEN-1:0] memInstr,
  output logic            illegalSeq
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  fetchStrb_t strb;
  logic [OPW-1:0] exOp;

  assign exOp = exInstr[XLEN-1 -: OPW];

  fetch_ctrl ctrl_i (
    .exOp    (exOp),
    .exSlot  (exDelaySlot),
    .brTaken (brTaken),
    .strb    (strb),
    .illegal (illegalSeq)
  );

  fetch_dp #(.XLEN(XLEN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .instrIn  (instrIn),
    .brTarget (brTarget),
    .strb     (strb),
    .pc       (pcOut),
    .exInstr  (exInstr),
    .exPc     (exPc),
    .exSlot   (exDelaySlot),
    .memInstr (memInstr)
  );

  // R3
  redirect_tgt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exOp == OP_BRANCH && brTaken && !exDelaySlot) |=> pcOut == $past(brTarget));

  // R8
  stray_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exOp != OP_BRANCH) |=> pcOut == $past(pcOut) + STEP);

  // R7
  illegal_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalSeq |=> pcOut == $past(pcOut) + STEP);

  // R7
  illegal_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalSeq |-> exDelaySlot);

  // R5
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exOp == OP_BRANCH) |=> exDelaySlot);

  // R5
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exOp != OP_BRANCH) |=> !exDelaySlot);
endmodule

// File: tb/delay_fetch_tb_top.sv
module delay_fetch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrIn, brTarget, pcOut, exInstr, exPc, memInstr;
  logic        brTaken, exDelaySlot, illegalSeq;
  logic        forceTk = 1'b0;
  logic [31:0] forceTgt = '0;
  logic [31:0] imem [0:63];
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Instruction memory and execute stub: bit 27 of a branch selects taken,
  // bits 15:0 give the word address of the target.
  assign instrIn  = imem[pcOut[7:2]];
  assign brTaken  = forceTk | (exInstr[31:28] == 4'hC && exInstr[27]);
  assign brTarget = forceTk ? forceTgt : {14'b0, exInstr[15:0], 2'b00};

  delay_fetch dut_i (
    .clk(clk), .rstN(rstN), .instrIn(instrIn), .brTaken(brTaken),
    .brTarget(brTarget), .pcOut(pcOut), .exInstr(exInstr), .exPc(exPc),
    .exDelaySlot(exDelaySlot), .memInstr(memInstr), .illegalSeq(illegalSeq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0000_0000 | 32'(i + 1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] br(input bit tk, input logic [15:0] wordTgt);
    return {4'hC, tk, 11'b0, wordTgt};
  endfunction

  task automatic testReset();
    clearMem();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", pcOut, 32'h0);
    chk("R1 exInstr in reset", exInstr, 32'h0);
    rstN = 1'b1;
    chk("R1 memInstr", memInstr, 32'h0);
    chk("R1 exPc", exPc, 32'h0);
    chk("R1 flags", {30'b0, exDelaySlot, illegalSeq}, 32'h0);
  endtask

  task automatic testSequential();
    clearMem();
    doReset();
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R2 pc step", pcOut, 32'(4 * k));
      chk("R2 exPc", exPc, 32'(4 * (k - 1)));
      chk("R2 exInstr", exInstr, 32'(k));
    end
  endtask

  task automatic testTaken();
    clearMem();
    imem[1] = br(1'b1, 16'h0010);
    doReset();
    @(negedge clk);
    @(negedge clk);
    chk("R3 branch in ex", exPc, 32'h4);
    chk("R5 branch not slot", {31'b0, exDelaySlot}, 32'h0);
    @(negedge clk);
    chk("R3 slot executes", exPc, 32'h8);
    chk("R3 slot word", exInstr, 32'h3);
    chk("R5 slot flag", {31'b0, exDelaySlot}, 32'h1);
    chk("R3 pc at target", pcOut, 32'h40);
    @(negedge clk);
    chk("R3 target executes", exPc, 32'h40);
    chk("R5 flag cleared", {31'b0, exDelaySlot}, 32'h0);
  endtask

  task automatic testNotTaken();
    clearMem();
    imem[1] = br(1'b0, 16'h0010);
    doReset();
    repeat (3) @(negedge clk);
    chk("R4 slot executes", exPc, 32'h8);
    chk("R5 slot flag not-taken", {31'b0, exDelaySlot}, 32'h1);
    chk("R4 pc sequential", pcOut, 32'hC);
    @(negedge clk);
    chk("R4 next in order", exPc, 32'hC);
    chk("R5 flag cleared not-taken", {31'b0, exDelaySlot}, 32'h0);
  endtask

  task automatic testMem();
    clearMem();
    imem[0] = 32'h8000_0005;
    imem[2] = 32'h9000_0007;
    doReset();
    @(negedge clk);
    chk("R6 load in ex", exInstr, 32'h8000_0005);
    @(negedge clk);
    chk("R6 load in mem", memInstr, 32'h8000_0005);
    @(negedge clk);
    chk("R6 alu skips mem", memInstr, 32'h0);
    @(negedge clk);
    chk("R6 store in mem", memInstr, 32'h9000_0007);
  endtask

  task automatic testIllegal();
    clearMem();
    imem[1] = br(1'b1, 16'h0010);
    imem[2] = br(1'b1, 16'h0020);
    doReset();
    repeat (3) @(negedge clk);
    chk("R7 illegal flag", {31'b0, illegalSeq}, 32'h1);
    chk("R7 outer target", pcOut, 32'h40);
    @(negedge clk);
    chk("R7 inner ignored pc", pcOut, 32'h44);
    chk("R7 outer target runs", exPc, 32'h40);
    chk("R7 flag drops", {31'b0, illegalSeq}, 32'h0);
  endtask

  task automatic testStray();
    clearMem();
    doReset();
    @(negedge clk);
    forceTk = 1'b1;
    forceTgt = 32'h100;
    @(negedge clk);
    forceTk = 1'b0;
    chk("R8 stray taken ignored", pcOut, 32'h8);
    @(negedge clk);
    chk("R8 flow unchanged", exPc, 32'h8);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    testReset();
    testSequential();
    testTaken();
    testNotTaken();
    testMem();
    testIllegal();
    testStray();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule